// File: doc/BRIEF.md
# USB Host Transaction Sequencer

This block runs one host-side USB transaction at a time on behalf of the processor. Software first loads a 7-bit target address and a small endpoint control word. It then writes a token command byte, and that write starts the transaction. The sequencer reads the buffer descriptor that is current for the token's endpoint and direction. Each endpoint direction has an even and an odd descriptor, used alternately. If the processor has handed the descriptor over, the sequencer asks a packet-level link layer to send the token, move the data and return the handshake.

When the transaction ends, the outcome goes into the descriptor's PID field and ownership returns to software. A sticky transfer-done flag is raised, and a sticky stall flag is raised as well when the device stalled. The sequencer retries NAKed transactions without limit unless retries are turned off. It gives up with an error code when the link layer stays silent too long. A separate counter watches the bus for a single-ended zero held longer than 2.5 microseconds and flags a detach.

Top module: `usbh_xact_top`

## Requirements
- R1: A write to the token command byte starts a transaction only when the sequencer is idle and the PID in bits 7:4 is IN (0x9), OUT (0x1) or SETUP (0xD). Bits 3:0 give the endpoint. Any other PID, or a write made while a transaction is in progress, is ignored. Each attempt produces exactly one single-cycle `pkt_start`.
- R2: The target address register is 7 bits wide and reads zero after reset. It accepts any value from 0 to 127, and the value is presented on `pkt_addr` with every token.
- R3: A descriptor status word has ownership in bit 15, the data toggle in bit 14 (0 = DATA0), the PID field in bits 13:10 and the byte count in bits 9:0. If bit 15 is clear, the descriptor is neither sent nor written back, and no flag is raised.
- R4: The descriptor index is {endpoint, dir, odd}. Here dir = 0 (receive) for IN and 1 (transmit) for OUT and SETUP. The odd selector of every endpoint direction starts at even (0) and inverts after each completion whose outcome is not NAK.
- R5: On completion the descriptor is written back with bit 15 cleared, the outcome in bits 13:10, and the toggle and byte count unchanged. The transfer-done flag is set at the same time.
- R6: When retry-disable is clear, a NAK makes the sequencer reissue the same token. Nothing is written back, and this repeats until some other outcome arrives.
- R7: When retry-disable is set, a NAK is written back as PID 0xA and the transaction completes.
- R8: A STALL outcome (0xE) sets the stall flag as well as the transfer-done flag.
- R9: Endpoint control bit 2 (low speed) drives `pkt_ls`, and bit 0 (handshake enable) drives `pkt_hs_exp`. The descriptor's toggle bit drives `pkt_dts` and its byte count drives `pkt_len`.
- R10: If the link layer sends no result within TURN_TO cycles after `pkt_start`, the outcome is the error code 0xF and the transaction completes. This holds even when retries are enabled.
- R11: The detach flag is set once `line_se0` has been high on more than 2.5 us worth of consecutive clocks (CLK_MHZ*5/2 cycles). Any cycle without SE0 restarts the count.
- R12: The interrupt flags are sticky and are cleared by writing 1 to their bit. The bit order is {detach, stall, transfer-done}, and a flag being set wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also acts as the bus reset |
| tok_we | input | 1 | Token command write strobe |
| tok_wdata | input | 8 | Token command: PID in bits 7:4, endpoint in bits 3:0 |
| addr_we | input | 1 | Target address write strobe |
| addr_wdata | input | 7 | Target address write value |
| dev_addr | output | 7 | Current target address |
| ctl_we | input | 1 | Endpoint control write strobe |
| ctl_wdata | input | 3 | Bit 2 low speed, bit 1 retry disable, bit 0 handshake enable |
| irq_clr_we | input | 1 | Flag clear strobe |
| irq_clr | input | 3 | Write-1-to-clear mask, {detach, stall, done} |
| irq_flags | output | 3 | Sticky flags, {detach, stall, done} |
| bd_req | output | 1 | Descriptor read request; data returns on the next cycle |
| bd_we | output | 1 | Descriptor status write-back strobe |
| bd_idx | output | EP_W+2 (6) | Descriptor index {endpoint, dir, odd} |
| bd_wdata | output | 16 | Status word written back |
| bd_rdata | input | 16 | Status word read, valid one cycle after bd_req |
| pkt_start | output | 1 | Start a token/data/handshake exchange |
| pkt_pid | output | 4 | Token PID |
| pkt_ep | output | EP_W (4) | Token endpoint |
| pkt_addr | output | 7 | Token device address |
| pkt_ls | output | 1 | Low-speed transaction |
| pkt_hs_exp | output | 1 | A handshake is expected |
| pkt_dts | output | 1 | Data toggle to use |
| pkt_len | output | 10 | Byte count from the descriptor |
| pkt_done | input | 1 | Link layer result strobe |
| pkt_result | input | 4 | Handshake or data PID seen by the link layer |
| line_se0 | input | 1 | Bus is in single-ended zero |

## Verification
Some properties are checked on every cycle. A write-back always releases ownership. `pkt_start` never lasts more than one cycle. The turnaround counter never exceeds its limit. The done and stall flags rise only right after a write-back, and a raised stall flag comes from a STALL outcome. A detach pulse only occurs while SE0 is present. Other behaviours can only be shown by the bench scenarios:
- The alternation between even and odd descriptors across transactions.
- The exact number of NAK retries, with and without retry-disable.
- That a descriptor not owned by the sequencer is left untouched.
- The timeout under enabled retries.
- The exact SE0 length that separates a detach from a glitch.

// File: rtl/usbh_pkg.sv
package usbh_pkg;
  localparam logic [3:0] PID_OUT   = 4'h1;
  localparam logic [3:0] PID_IN    = 4'h9;
  localparam logic [3:0] PID_SETUP = 4'hD;
  localparam logic [3:0] PID_NAK   = 4'hA;
  localparam logic [3:0] PID_STALL = 4'hE;
  localparam logic [3:0] PID_ERR   = 4'hF;

  localparam int BD_OWN = 15;
  localparam int BD_DTS = 14;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_ISSUE, S_WAIT, S_WBACK
  } seq_state_e;
endpackage

// File: rtl/usbh_detach.sv
module usbh_detach #(
  parameter int CLK_MHZ = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic se0,
  output logic det_pulse
);
  localparam int LIMIT = (CLK_MHZ * 5) / 2;
  localparam int DW    = $clog2(LIMIT + 1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          at_lim;

  assign at_lim = (cnt_q == LIMIT[DW-1:0]);

  always_comb begin
    if (!se0)        cnt_d = '0;
    else if (at_lim) cnt_d = cnt_q;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign det_pulse = se0 && at_lim;

  p_detach_needs_se0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse |-> $past(se0));
endmodule

// File: rtl/usbh_seq.sv
module usbh_seq
  import usbh_pkg::*;
#(
  parameter int NUM_EP  = 16,
  parameter int TURN_TO = 64,
  parameter int EP_W    = $clog2(NUM_EP),
  parameter int IDX_W   = EP_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_we,
  input  logic [7:0]       tok_wdata,
  input  logic             retry_dis,
  output logic             bd_req,
  output logic             bd_we,
  output logic [IDX_W-1:0] bd_idx,
  output logic [15:0]      bd_wdata,
  input  logic [15:0]      bd_rdata,
  output logic             pkt_start,
  output logic [3:0]       pkt_pid,
  output logic [EP_W-1:0]  pkt_ep,
  output logic             pkt_dts,
  output logic [9:0]       pkt_len,
  input  logic             pkt_done,
  input  logic [3:0]       pkt_result,
  output logic             done_pulse,
  output logic             stall_pulse
);
  localparam int TMO_W = $clog2(TURN_TO + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TURN_TO - 1);

  seq_state_e          state_q, state_d;
  logic [3:0]          pid_q, pid_d;
  logic [EP_W-1:0]     ep_q, ep_d;
  logic [15:0]         stat_q, stat_d;
  logic [3:0]          res_q, res_d;
  logic [TMO_W-1:0]    tmo_q, tmo_d;
  logic [2*NUM_EP-1:0] pp_q, pp_d;
  logic                dir, tok_ok;
  logic [EP_W:0]       sel;

  assign tok_ok = tok_we && (state_q == S_IDLE) &&
                  (tok_wdata[7:4] == PID_IN || tok_wdata[7:4] == PID_OUT ||
                   tok_wdata[7:4] == PID_SETUP);
  assign dir    = (pid_q != PID_IN);
  assign sel    = {ep_q, dir};
  assign bd_idx = {ep_q, dir, pp_q[sel]};

  always_comb begin
    state_d = state_q; pid_d = pid_q; ep_d = ep_q; stat_d = stat_q;
    res_d = res_q; tmo_d = tmo_q; pp_d = pp_q;
    bd_req = 1'b0; bd_we = 1'b0; pkt_start = 1'b0;
    done_pulse = 1'b0; stall_pulse = 1'b0;
    case (state_q)
      S_IDLE: if (tok_ok) begin
        pid_d   = tok_wdata[7:4];
        ep_d    = tok_wdata[EP_W-1:0];
        state_d = S_FETCH;
      end
      S_FETCH: begin
        bd_req  = 1'b1;
        state_d = S_CHECK;
      end
      S_CHECK: begin
        stat_d  = bd_rdata;
        state_d = bd_rdata[BD_OWN] ? S_ISSUE : S_IDLE;
      end
      S_ISSUE: begin
        pkt_start = 1'b1;
        tmo_d     = '0;
        state_d   = S_WAIT;
      end
      S_WAIT: begin
        if (pkt_done) begin
          if (pkt_result == PID_NAK && !retry_dis) state_d = S_ISSUE;
          else begin
            res_d   = pkt_result;
            state_d = S_WBACK;
          end
        end else if (tmo_q == TMO_LAST) begin
          res_d   = PID_ERR;
          state_d = S_WBACK;
        end else begin
          tmo_d = tmo_q + 1'b1;
        end
      end
      S_WBACK: begin
        bd_we       = 1'b1;
        done_pulse  = 1'b1;
        stall_pulse = (res_q == PID_STALL);
        if (res_q != PID_NAK) pp_d[sel] = ~pp_q[sel];
        state_d     = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= S_IDLE;
      pid_q   <= '0;
      ep_q    <= '0;
      stat_q  <= '0;
      res_q   <= '0;
      tmo_q   <= '0;
      pp_q    <= '0;
    end else begin
      state_q <= state_d;
      pid_q   <= pid_d;
      ep_q    <= ep_d;
      stat_q  <= stat_d;
      res_q   <= res_d;
      tmo_q   <= tmo_d;
      pp_q    <= pp_d;
    end

  assign bd_wdata = {1'b0, stat_q[BD_DTS], res_q, stat_q[9:0]};
  assign pkt_pid  = pid_q;
  assign pkt_ep   = ep_q;
  assign pkt_dts  = stat_q[BD_DTS];
  assign pkt_len  = stat_q[9:0];

  p_wb_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bd_we |-> !bd_wdata[BD_OWN]);
  p_start_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> !pkt_start);
  p_start_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> stat_q[BD_OWN]);
  p_tmo_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q < TMO_W'(TURN_TO));
endmodule

// File: rtl/usbh_xact_top.sv
module usbh_xact_top #(
  parameter int NUM_EP  = 16,
  parameter int TURN_TO = 64,
  parameter int CLK_MHZ = 250,
  parameter int EP_W    = $clog2(NUM_EP),
  parameter int IDX_W   = EP_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_we,
  input  logic [7:0]       tok_wdata,
  input  logic             addr_we,
  input  logic [6:0]       addr_wdata,
  output logic [6:0]       dev_addr,
  input  logic             ctl_we,
  input  logic [2:0]       ctl_wdata,
  input  logic             irq_clr_we,
  input  logic [2:0]       irq_clr,
  output logic [2:0]       irq_flags,
  output logic             bd_req,
  output logic             bd_we,
  output logic [IDX_W-1:0] bd_idx,
  output logic [15:0]      bd_wdata,
  input  logic [15:0]      bd_rdata,
  output logic             pkt_start,
  output logic [3:0]       pkt_pid,
  output logic [EP_W-1:0]  pkt_ep,
  output logic [6:0]       pkt_addr,
  output logic             pkt_ls,
  output logic             pkt_hs_exp,
  output logic             pkt_dts,
  output logic [9:0]       pkt_len,
  input  logic             pkt_done,
  input  logic [3:0]       pkt_result,
  input  logic             line_se0
);
  logic [6:0] addr_q, addr_d;
  logic [2:0] ctl_q, ctl_d;
  logic [2:0] flag_q, flag_d, flag_set;
  logic       done_pulse, stall_pulse, det_pulse;

  usbh_seq #(.NUM_EP(NUM_EP), .TURN_TO(TURN_TO), .EP_W(EP_W), .IDX_W(IDX_W)) u_seq (
    .clk, .rst_n, .tok_we, .tok_wdata, .retry_dis(ctl_q[1]),
    .bd_req, .bd_we, .bd_idx, .bd_wdata, .bd_rdata,
    .pkt_start, .pkt_pid, .pkt_ep, .pkt_dts, .pkt_len,
    .pkt_done, .pkt_result, .done_pulse, .stall_pulse
  );

  usbh_detach #(.CLK_MHZ(CLK_MHZ)) u_det (
    .clk, .rst_n, .se0(line_se0), .det_pulse
  );

  assign flag_set = {det_pulse, stall_pulse, done_pulse};

  always_comb begin
    addr_d = addr_we ? addr_wdata : addr_q;
    ctl_d  = ctl_we  ? ctl_wdata  : ctl_q;
    flag_d = (flag_q & ~(irq_clr_we ? irq_clr : 3'b000)) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q <= '0;
      ctl_q  <= '0;
      flag_q <= '0;
    end else begin
      addr_q <= addr_d;
      ctl_q  <= ctl_d;
      flag_q <= flag_d;
    end

  assign dev_addr   = addr_q;
  assign pkt_addr   = addr_q;
  assign pkt_ls     = ctl_q[2];
  assign pkt_hs_exp = ctl_q[0];
  assign irq_flags  = flag_q;

  p_done_after_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flags[0]) |-> $past(bd_we));
  p_stall_from_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flags[1]) |-> $past(bd_we && bd_wdata[13:10] == 4'hE));
  p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_flags[0]) && !$past(irq_clr_we)) |-> irq_flags[0]);
endmodule

// File: tb/usbh_xact_top_test.sv
module usbh_xact_top_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_we = 0, addr_we = 0, ctl_we = 0, irq_clr_we = 0, line_se0 = 0;
  logic [7:0] tok_wdata = 0;
  logic [6:0] addr_wdata = 0;
  logic [2:0] ctl_wdata = 0, irq_clr = 0;
  logic [6:0] dev_addr, pkt_addr;
  logic [2:0] irq_flags;
  logic bd_req, bd_we, pkt_start, pkt_ls, pkt_hs_exp, pkt_dts, pkt_done;
  logic [5:0] bd_idx;
  logic [15:0] bd_wdata, bd_rdata;
  logic [3:0] pkt_pid, pkt_result, pkt_ep;
  logic [9:0] pkt_len;

  int errors = 0, checks = 0;
  logic [15:0] mem [0:63];
  int start_cnt = 0, base_cnt = 0, nak_cfg = 0, wb_cnt = 0, dly = 0;
  logic silent = 0;
  logic [3:0] final_res = 4'h2;
  logic [5:0] wb_idx;
  logic [3:0] cap_pid; logic [6:0] cap_addr; logic cap_ls, cap_hs, cap_dts;
  logic [9:0] cap_len;

  always #2 clk = ~clk;

  usbh_xact_top uut (.*);

  always @(posedge clk) begin
    if (bd_req) bd_rdata <= mem[bd_idx];
    if (bd_we) begin mem[bd_idx] <= bd_wdata; wb_idx <= bd_idx; wb_cnt <= wb_cnt + 1; end
  end

  assign pkt_done   = (dly == 1);
  assign pkt_result = ((start_cnt - base_cnt) <= nak_cfg) ? 4'hA : final_res;

  always @(posedge clk) begin
    if (pkt_start) begin
      start_cnt <= start_cnt + 1;
      cap_pid <= pkt_pid; cap_addr <= pkt_addr; cap_ls <= pkt_ls;
      cap_hs <= pkt_hs_exp; cap_dts <= pkt_dts; cap_len <= pkt_len;
      dly <= silent ? 0 : 3;
    end else if (dly > 0) dly <= dly - 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_tok(logic [7:0] v);
    @(negedge clk); tok_we = 1; tok_wdata = v; @(negedge clk); tok_we = 0;
  endtask
  task automatic wr_ctl(logic [2:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v; @(negedge clk); ctl_we = 0;
  endtask
  task automatic clr_flags(logic [2:0] m);
    @(negedge clk); irq_clr_we = 1; irq_clr = m; @(negedge clk); irq_clr_we = 0;
  endtask
  task automatic wait_done();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq_flags[0]) break;
    end
  endtask
  task automatic run_xact(logic [7:0] tok, int naks, logic [3:0] res);
    clr_flags(3'b111);
    base_cnt = start_cnt; nak_cfg = naks; final_res = res;
    wr_tok(tok);
    wait_done();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R2 reset addr", dev_addr, 7'd0);
    check("R12 reset flags", irq_flags, 3'b000);
    check("R1 reset start", pkt_start, 1'b0);
  endtask

  task automatic t_addr();
    @(negedge clk); addr_we = 1; addr_wdata = 7'd127; @(negedge clk); addr_we = 0;
    check("R2 addr 127", dev_addr, 7'd127);
    @(negedge clk); addr_we = 1; addr_wdata = 7'd5; @(negedge clk); addr_we = 0;
    check("R2 addr 5", dev_addr, 7'd5);
  endtask

  task automatic t_setup();
    wr_ctl(3'b001);
    mem[2] = 16'h8008;
    run_xact(8'hD0, 0, 4'h2);
    check("R5 setup writeback", mem[2], 16'h0808);
    check("R4 setup idx", wb_idx, 6'd2);
    check("R1 setup pid", cap_pid, 4'hD);
    check("R2 token addr", cap_addr, 7'd5);
    check("R9 len", cap_len, 10'd8);
    check("R9 ls off hs on", {cap_ls, cap_hs}, 2'b01);
    check("R5 done flag", irq_flags, 3'b001);
  endtask

  task automatic t_in_pingpong();
    mem[0] = 16'hC040; mem[1] = 16'h8010;
    run_xact(8'h90, 0, 4'hB);
    check("R4 in even idx", wb_idx, 6'd0);
    check("R9 dts", cap_dts, 1'b1);
    check("R5 in even wb", mem[0], 16'h6C40);
    run_xact(8'h90, 0, 4'h3);
    check("R4 in odd idx", wb_idx, 6'd1);
    check("R5 in odd wb", mem[1], 16'h0C10);
  endtask

  task automatic t_not_owned();
    int s0, w0;
    mem[3] = 16'h0005;
    s0 = start_cnt; w0 = wb_cnt;
    clr_flags(3'b111);
    wr_tok(8'h10);
    repeat (20) @(negedge clk);
    check("R3 no start", start_cnt - s0, 0);
    check("R3 no wb", wb_cnt - w0, 0);
    check("R3 mem kept", mem[3], 16'h0005);
    check("R3 no flag", irq_flags, 3'b000);
  endtask

  task automatic t_nak_retry();
    int s0;
    mem[3] = 16'h8004;
    s0 = start_cnt;
    run_xact(8'h10, 3, 4'h2);
    check("R6 retry count", start_cnt - s0, 4);
    check("R6 final wb", mem[3], 16'h0804);
    check("R4 odd tx idx", wb_idx, 6'd3);
  endtask

  task automatic t_nak_report();
    int s0;
    wr_ctl(3'b111);
    mem[2] = 16'h8000;
    s0 = start_cnt;
    run_xact(8'h10, 3, 4'h2);
    check("R7 single start", start_cnt - s0, 1);
    check("R7 nak wb", mem[2], 16'h2800);
    check("R9 ls on", {cap_ls, cap_hs}, 2'b11);
    mem[2] = 16'h8001;
    run_xact(8'h10, 0, 4'h2);
    check("R4 no toggle after nak", wb_idx, 6'd2);
    check("R7 ack wb", mem[2], 16'h0801);
  endtask

  task automatic t_stall();
    mem[0] = 16'h8000;
    run_xact(8'h90, 0, 4'hE);
    check("R8 stall wb", mem[0], 16'h3800);
    check("R8 stall flags", irq_flags, 3'b011);
    clr_flags(3'b010);
    check("R12 w1c stall only", irq_flags, 3'b001);
  endtask

  task automatic t_timeout();
    int s0;
    wr_ctl(3'b001);
    mem[1] = 16'h8002;
    silent = 1;
    s0 = start_cnt;
    clr_flags(3'b111);
    wr_tok(8'h90);
    repeat (10) @(negedge clk);
    wr_tok(8'h10);
    wr_tok(8'h50);
    wait_done();
    repeat (2) @(negedge clk);
    check("R10 timeout wb", mem[1], 16'h3C02);
    check("R10 done flag", irq_flags[0], 1'b1);
    check("R1 busy write ignored", start_cnt - s0, 1);
    silent = 0;
    s0 = start_cnt;
    wr_tok(8'h50);
    repeat (10) @(negedge clk);
    check("R1 bad pid ignored", start_cnt - s0, 0);
  endtask

  task automatic se0_for(int n);
    @(negedge clk); line_se0 = 1;
    repeat (n) @(negedge clk);
    line_se0 = 0;
  endtask

  task automatic t_detach();
    clr_flags(3'b111);
    se0_for(625);
    repeat (3) @(negedge clk);
    check("R11 625 cycles no detach", irq_flags[2], 1'b0);
    se0_for(400);
    se0_for(400);
    repeat (3) @(negedge clk);
    check("R11 broken se0 no detach", irq_flags[2], 1'b0);
    se0_for(626);
    repeat (3) @(negedge clk);
    check("R11 626 cycles detach", irq_flags[2], 1'b1);
    repeat (3) @(negedge clk);
    check("R12 detach sticky", irq_flags[2], 1'b1);
    clr_flags(3'b100);
    check("R12 detach cleared", irq_flags[2], 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_addr();
    t_setup();
    t_in_pingpong();
    t_not_owned();
    t_nak_retry();
    t_nak_report();
    t_stall();
    t_timeout();
    t_detach();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule